// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers four shared PCI interrupt request lines onto a bank of sixteen legacy interrupt-controller inputs. Each request line has a byte-wide steering register. A value below 16 selects the controller input that the line drives. A value of 16 or more leaves the line unrouted. Several request lines may be steered onto the same controller input, and that input is then the OR of all of them.

The block holds a 64-bit level map with one bit for each pair of controller input and request line, at bit index `irq*4 + line`. Each controller output is the OR of its four bits. A level change updates only the bit of its own line at that line's current destination. A write to any steering register clears the whole map and rebuilds it in the same clock from the new steering values and the current request levels. The block also gives a combinational route query for each line. A separate combinational helper folds a device's slot number and INTx pin onto a request line.

Top module: `pirq_router`

## Requirements
- R1: After reset, the four steering registers read back 0x80, `irq_out` is all zero and every `route_en` bit is low.
- R2: A write with `cfg_addr` in 0x60..0x63 stores `cfg_wdata` into the register of line `cfg_addr-0x60`. A read from that address returns the stored byte unchanged, including values of 16 and above. Any other address reads 0x00, and a write to it changes no steering register.
- R3: For each line p, `route_en[p]` is 1 and `route_irq[5p+4:5p]` equals the stored value when that value is below 16. Otherwise `route_en[p]` is 0 and the 5-bit field is 5'b11111, which is -1 in two's complement.
- R4: While line p is steered to input n, a change on `pirq_lvl[p]` appears on `irq_out[n]` one clock edge later.
- R5: `irq_out[n]` is the OR of the levels of every line steered to n, so several lines can share one output.
- R6: A line whose steering value is 16 or more drives no output bit at any level.
- R7: A steering write clears the map and rebuilds it from the current levels. After the write's clock edge, the old destination no longer carries the line, and the new destination reflects its level.
- R8: `slot_pirq` equals `(slot_intx + slot_dev - 1) mod 4`. Device number 0 wraps, so it gives `slot_intx - 1 mod 4`.
- R9: A level change in the same cycle as a steering write to that line is applied using the new steering value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| pirq_lvl | input | 4 | Level of each shared request line |
| irq_out | output | 16 | Level to each controller input |
| route_en | output | 4 | Per line: steering is active |
| route_irq | output | 20 | Per line: 5-bit destination, all ones when unrouted |
| slot_dev | input | 5 | Device number of the querying slot |
| slot_intx | input | 2 | INTx pin of the querying slot (A=0 .. D=3) |
| slot_pirq | output | 2 | Request line that the slot pin folds onto |

## Verification
The checker assumes that `pirq_lvl` and the write port are sampled only at the rising edge. It also assumes that the count of asserted outputs can never exceed the count of request lines that were high one cycle earlier, which holds only because the map is rebuilt on every steering write. The bench drives every input on the falling edge and samples on the next falling edge, so each registered effect is observed exactly one edge after its stimulus. The sweeps cover every steering value from 0 to 19 on every line, all sixteen level patterns over a shared configuration, and every slot and pin combination.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NPIRQ = 4,
  parameter int NIRQ  = 16,
  parameter int DEVW  = 5,
  parameter logic [7:0] BASE      = 8'h60,
  parameter logic [7:0] RST_ROUTE = 8'h80
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [7:0]                    cfg_addr,
  input  logic [7:0]                    cfg_wdata,
  output logic [7:0]                    cfg_rdata,
  input  logic [NPIRQ-1:0]              pirq_lvl,
  output logic [NIRQ-1:0]               irq_out,
  output logic [NPIRQ-1:0]              route_en,
  output logic [NPIRQ*($clog2(NIRQ)+1)-1:0] route_irq,
  input  logic [DEVW-1:0]               slot_dev,
  input  logic [$clog2(NPIRQ)-1:0]      slot_intx,
  output logic [$clog2(NPIRQ)-1:0]      slot_pirq
);
  localparam int PW = $clog2(NPIRQ);
  localparam int IW = $clog2(NIRQ);
  localparam int QW = IW + 1;
  localparam int MW = NIRQ * NPIRQ;
  localparam logic [8:0] NP9 = 9'(NPIRQ);
  localparam logic [7:0] NI8 = 8'(NIRQ);

  logic [7:0]    route_q [NPIRQ];
  logic [7:0]    route_n [NPIRQ];
  logic [MW-1:0] map_q, map_d;
  logic [8:0]    off;
  logic          in_win, hit;
  logic [PW-1:0] sel;
  logic [DEVW-1:0] fold;

  assign off    = {1'b0, cfg_addr} - {1'b0, BASE};
  assign in_win = off < NP9;
  assign hit    = cfg_we && in_win;
  assign sel    = off[PW-1:0];
  assign cfg_rdata = in_win ? route_q[sel] : 8'h00;

  assign fold      = slot_dev + DEVW'(slot_intx) - DEVW'(1);
  assign slot_pirq = fold[PW-1:0];

  for (genvar p = 0; p < NPIRQ; p++) begin : g_line
    assign route_n[p] = (hit && sel == PW'(p)) ? cfg_wdata : route_q[p];
    assign route_en[p] = route_q[p] < NI8;
    assign route_irq[p*QW +: QW] = route_en[p] ? {1'b0, route_q[p][IW-1:0]} : {QW{1'b1}};

    always_ff @(posedge clk) begin
      if (!rst_n) route_q[p] <= RST_ROUTE;
      else        route_q[p] <= route_n[p];
    end
  end

  always_comb begin
    map_d = hit ? '0 : map_q;
    for (int p = 0; p < NPIRQ; p++) begin
      if (route_n[p] < NI8)
        map_d[int'(route_n[p][IW-1:0]) * NPIRQ + p] = pirq_lvl[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_out
    assign irq_out[i] = |map_q[i*NPIRQ +: NPIRQ];
  end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NPIRQ = 4,
  parameter int NIRQ  = 16,
  parameter int DEVW  = 5,
  parameter logic [7:0] BASE = 8'h60
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we,
  input logic [7:0]                    cfg_addr,
  input logic [7:0]                    cfg_wdata,
  input logic [NPIRQ-1:0]              pirq_lvl,
  input logic [NIRQ-1:0]               irq_out,
  input logic [NPIRQ-1:0]              route_en,
  input logic [NPIRQ*($clog2(NIRQ)+1)-1:0] route_irq,
  input logic [DEVW-1:0]               slot_dev,
  input logic [$clog2(NPIRQ)-1:0]      slot_intx,
  input logic [$clog2(NPIRQ)-1:0]      slot_pirq
);
  localparam int IW = $clog2(NIRQ);
  logic [NPIRQ-1:0] lvl_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= pirq_lvl;
  end

  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pirq_lvl == '0 |=> irq_out == '0);

  assert_fanin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(lvl_prev));

  assert_unrouted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == BASE && cfg_wdata >= 8'(NIRQ) |=> !route_en[0]);

  assert_query_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == BASE && cfg_wdata < 8'(NIRQ)
    |=> route_en[0] && route_irq[IW-1:0] == $past(cfg_wdata[IW-1:0]));

  assert_slot1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_dev == DEVW'(1) |-> slot_pirq == slot_intx);
endmodule

bind pirq_router pirq_router_chk #(.NPIRQ(NPIRQ), .NIRQ(NIRQ), .DEVW(DEVW), .BASE(BASE)) chk_i (.*);

// File: tb/pirq_router_tb_top.sv
module pirq_router_tb_top;
  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic [3:0] pirq_lvl = 0, route_en;
  logic [15:0] irq_out;
  logic [19:0] route_irq;
  logic [4:0] slot_dev = 0;
  logic [1:0] slot_intx = 0, slot_pirq;
  int checks = 0, errors = 0;
  logic [7:0] rt [4];

  always #5 clk = ~clk;

  pirq_router dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(logic [3:0] lv);
    logic [15:0] r = 0;
    for (int p = 0; p < 4; p++) if (lv[p] && rt[p] < 16) r[rt[p][3:0]] = 1'b1;
    return r;
  endfunction

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    if (a >= 8'h60 && a <= 8'h63) rt[a[1:0]] = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic lvl(logic [3:0] v);
    @(negedge clk); pirq_lvl = v; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int p = 0; p < 4; p++) rt[p] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin rd(8'(8'h60 + p), d); chk("R1 reg", 32'(d), 32'h80); end
    chk("R1 out", 32'(irq_out), 0);
    chk("R1 en", 32'(route_en), 0);

    wr(8'h64, 8'h03); wr(8'h5F, 8'h03);
    rd(8'h64, d); chk("R2 outside read", 32'(d), 0);
    rd(8'h5F, d); chk("R2 outside read", 32'(d), 0);
    for (int p = 0; p < 4; p++) begin rd(8'(8'h60 + p), d); chk("R2 outside write", 32'(d), 32'h80); end

    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 20; v++) begin
        wr(8'(8'h60 + p), 8'(v));
        rd(8'(8'h60 + p), d); chk("R2 readback", 32'(d), 32'(v));
        chk("R3 en", 32'(route_en[p]), 32'(v < 16));
        chk("R3 irq", 32'(route_irq[p*5 +: 5]), v < 16 ? 32'(v) : 32'h1F);
        lvl(4'(1 << p));
        chk(v < 16 ? "R4 level high" : "R6 unrouted", 32'(irq_out), 32'(model(4'(1 << p))));
        lvl(4'h0);
        chk("R4 level low", 32'(irq_out), 0);
      end
      wr(8'(8'h60 + p), 8'h80);
    end

    wr(8'h60, 8'd5); wr(8'h61, 8'd5); wr(8'h62, 8'd9); wr(8'h63, 8'd5);
    for (int v = 0; v < 16; v++) begin
      lvl(4'(v));
      chk("R5 shared OR", 32'(irq_out), 32'(model(4'(v))));
    end
    lvl(4'h0);

    wr(8'h62, 8'd3); lvl(4'b0100);
    chk("R7 before", 32'(irq_out), 32'h0008);
    wr(8'h62, 8'd7);
    chk("R7 moved", 32'(irq_out), 32'h0080);
    wr(8'h62, 8'h90);
    chk("R7 to unrouted", 32'(irq_out), 0);
    lvl(4'h0);

    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'h61; cfg_wdata = 8'd11; rt[1] = 8'd11; pirq_lvl = 4'b0010;
    @(negedge clk); cfg_we = 0;
    chk("R9 same cycle", 32'(irq_out), 32'h0800);
    lvl(4'h0);

    for (int dv = 0; dv < 32; dv++)
      for (int ix = 0; ix < 4; ix++) begin
        slot_dev = 5'(dv); slot_intx = 2'(ix); #1;
        chk("R8 slot", 32'(slot_pirq), 32'((ix + dv + 3) % 4));
      end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule